// File: doc/BRIEF.md
# Thread-Block Warp Former

This unit turns the shape of a thread block, given as three extents along x, y and z, into a run of warp descriptors. Each warp covers 32 consecutive thread numbers and starts on a multiple of 32. For every one of its 32 lane slots the descriptor gives the thread's linear number, its (x, y, z) position inside the block and a flag that says whether the lane holds a real thread. A launch sequencer pulses `start` with the shape on the dimension inputs. It then drains the warps through a valid/ready pair, one warp per accepted cycle, until `done` pulses.

Thread numbers run with x fastest, then y, then z, so thread (x, y, z) gets the number x + y·Dx + z·Dx·Dy. The per-lane coordinates come from an unrolled chain of incrementers with carry across the three axes, seeded by the coordinate of the warp's first thread, so the unit needs no divider. A shape that breaks the size limits is refused with an error flag and produces no warps.

Top module: `warp_former`

## Requirements
- R1: The first warp has base thread number 0 and warp w has base 32·w; lane l of a warp carries the thread number base + l on `laneTid` bits [l·11 +: 11].
- R2: For an active lane with thread number t, `laneX`, `laneY` and `laneZ` (fields of 11, 11 and 7 bits at lane offsets l·11, l·11 and l·7) equal t mod Dx, (t div Dx) mod Dy and t div (Dx·Dy).
- R3: Bit l of `activeMask` is 1 exactly when base + l is below Dx·Dy·Dz; an inactive lane drives zero on its thread number and its three coordinates.
- R4: A legal shape yields ceil(Dx·Dy·Dz/32) warps, with `warpIdx` counting 0, 1, 2, … in order of acceptance.
- R5: A shape is legal when every extent is nonzero, Dx ≤ 1024, Dy ≤ 1024, Dz ≤ 64 and Dx·Dy·Dz ≤ 1024. An illegal shape sets `error` in the cycle after `start`, keeps `outValid` low, and `error` holds until the next `start`. A legal `start` clears it.
- R6: While `outValid` is high and `outReady` low, the descriptor (index, mask, base and lane fields) holds steady. With `outReady` held high, one warp is accepted on every clock.
- R7: `done` is high for exactly the one cycle after the final warp is accepted, and `outValid` is low in that cycle.
- R8: After reset `outValid`, `done` and `error` are low.
- R9: A `start` while warps are still pending drops the rest of the old shape and starts again at warp 0 of the new one.
- R10: After a legal `start`, `outValid` is high in the next cycle, presenting warp 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load the shape on the dimension inputs |
| dimX | input | 11 | Block extent along x |
| dimY | input | 11 | Block extent along y |
| dimZ | input | 7 | Block extent along z |
| outReady | input | 1 | Consumer accepts the current warp |
| outValid | output | 1 | A warp descriptor is presented |
| warpIdx | output | 5 | Index of the presented warp |
| activeMask | output | 32 | One bit per lane, set for a real thread |
| baseTid | output | 11 | Thread number of lane 0 |
| laneTid | output | 352 | Thread number per lane, 11 bits each |
| laneX | output | 352 | x position per lane, 11 bits each |
| laneY | output | 352 | y position per lane, 11 bits each |
| laneZ | output | 224 | z position per lane, 7 bits each |
| done | output | 1 | One-cycle pulse after the last warp is accepted |
| error | output | 1 | The last loaded shape was illegal |

## Verification
`outValid` and `error` respond one clock edge after `start`. A new descriptor appears one edge after each accepted cycle, and `done` rises one edge after the final acceptance. The bench drives inputs on falling edges and samples on the next falling edge, so every result is read exactly one register stage after its cause. Holding cycles with `outReady` low are inserted on alternate warps to confirm the descriptor holds still. A separate run with `outReady` tied high counts one warp per cycle.

// File: rtl/warp_pkg.sv
package warp_pkg;
  localparam int LANES_DEF   = 32;
  localparam int XY_W_DEF    = 11;
  localparam int Z_W_DEF     = 7;
  localparam int MAX_XY_DEF  = 1024;
  localparam int MAX_Z_DEF   = 64;
  localparam int MAX_THR_DEF = 1024;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch a new legal shape, rewind to warp 0
    logic advance;  // step to the next warp
  } dpCtl_t;
endpackage

// File: rtl/warp_ctrl.sv
module warp_ctrl
  import warp_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   shapeOk,
  input  logic   isLast,
  input  logic   outReady,
  output dpCtl_t ctl,
  output logic   outValid,
  output logic   done,
  output logic   error
);
  typedef enum logic {S_IDLE, S_EMIT} state_t;
  state_t state;

  logic fire;
  assign outValid = (state == S_EMIT);
  assign fire     = outValid && outReady;

  always_comb begin
    ctl.load    = start && shapeOk;
    ctl.advance = !start && fire && !isLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      done <= !start && fire && isLast;
      if (start) begin
        error <= !shapeOk;
        state <= shapeOk ? S_EMIT : S_IDLE;
      end else if (fire && isLast) begin
        state <= S_IDLE;
      end
    end
  end
endmodule

// File: rtl/warp_dp.sv
module warp_dp
  import warp_pkg::*;
#(
  parameter int LANES   = LANES_DEF,
  parameter int XY_W    = XY_W_DEF,
  parameter int Z_W     = Z_W_DEF,
  parameter int MAX_XY  = MAX_XY_DEF,
  parameter int MAX_Z   = MAX_Z_DEF,
  parameter int MAX_THR = MAX_THR_DEF,
  localparam int TID_W     = $clog2(MAX_THR + 1),
  localparam int MAX_WARPS = (MAX_THR + LANES - 1) / LANES,
  localparam int WIDX_W    = (MAX_WARPS > 1) ? $clog2(MAX_WARPS) : 1
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  dpCtl_t                 ctl,
  input  logic [XY_W-1:0]        dimX,
  input  logic [XY_W-1:0]        dimY,
  input  logic [Z_W-1:0]         dimZ,
  output logic                   shapeOk,
  output logic                   isLast,
  output logic [WIDX_W-1:0]      warpIdx,
  output logic [LANES-1:0]       activeMask,
  output logic [TID_W-1:0]       baseTid,
  output logic [LANES*TID_W-1:0] laneTid,
  output logic [LANES*XY_W-1:0]  laneX,
  output logic [LANES*XY_W-1:0]  laneY,
  output logic [LANES*Z_W-1:0]   laneZ
);
  localparam int PROD_W = 2 * XY_W + Z_W;
  localparam int LOG_L  = $clog2(LANES);

  // shape legality, evaluated on the raw inputs
  logic [PROD_W-1:0] prod;
  assign prod = PROD_W'(dimX) * PROD_W'(dimY) * PROD_W'(dimZ);
  assign shapeOk = (dimX != '0) && (dimY != '0) && (dimZ != '0) &&
                   (dimX <= XY_W'(MAX_XY)) && (dimY <= XY_W'(MAX_XY)) &&
                   (dimZ <= Z_W'(MAX_Z)) && (prod <= PROD_W'(MAX_THR));

  logic [XY_W-1:0]   shX, shY, bx, by;
  logic [Z_W-1:0]    shZ, bz;
  logic [TID_W-1:0]  totalR;
  logic [WIDX_W-1:0] lastIdx;

  // coordinate chain: entry i is the position of thread baseTid + i
  logic [XY_W-1:0] cx [LANES+1];
  logic [XY_W-1:0] cy [LANES+1];
  logic [Z_W-1:0]  cz [LANES+1];

  assign cx[0] = bx;
  assign cy[0] = by;
  assign cz[0] = bz;

  for (genvar i = 0; i < LANES; i++) begin : g_step
    logic xWrap, yWrap;
    assign xWrap = ((cx[i] + 1'b1) == shX);
    assign yWrap = xWrap && ((cy[i] + 1'b1) == shY);
    assign cx[i+1] = xWrap ? '0 : cx[i] + 1'b1;
    assign cy[i+1] = xWrap ? (yWrap ? '0 : cy[i] + 1'b1) : cy[i];
    assign cz[i+1] = yWrap ? cz[i] + 1'b1 : cz[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shX     <= '0;
      shY     <= '0;
      shZ     <= '0;
      totalR  <= '0;
      lastIdx <= '0;
      warpIdx <= '0;
      baseTid <= '0;
      bx      <= '0;
      by      <= '0;
      bz      <= '0;
    end else if (ctl.load) begin
      shX     <= dimX;
      shY     <= dimY;
      shZ     <= dimZ;
      totalR  <= TID_W'(prod);
      lastIdx <= WIDX_W'((TID_W'(prod) - 1'b1) >> LOG_L);
      warpIdx <= '0;
      baseTid <= '0;
      bx      <= '0;
      by      <= '0;
      bz      <= '0;
    end else if (ctl.advance) begin
      warpIdx <= warpIdx + 1'b1;
      baseTid <= baseTid + TID_W'(LANES);
      bx      <= cx[LANES];
      by      <= cy[LANES];
      bz      <= cz[LANES];
    end
  end

  assign isLast = (warpIdx == lastIdx);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [TID_W-1:0] tid;
    logic act;
    assign tid = baseTid + TID_W'(i);
    assign act = (tid < totalR);
    assign activeMask[i]               = act;
    assign laneTid[i*TID_W +: TID_W]   = act ? tid : '0;
    assign laneX[i*XY_W +: XY_W]       = act ? cx[i] : '0;
    assign laneY[i*XY_W +: XY_W]       = act ? cy[i] : '0;
    assign laneZ[i*Z_W +: Z_W]         = act ? cz[i] : '0;
  end

  // shZ is kept only so the loaded shape is complete; z never wraps
  logic unusedZ;
  assign unusedZ = ^shZ;
endmodule

// File: rtl/warp_former.sv
module warp_former
  import warp_pkg::*;
#(
  parameter int LANES   = LANES_DEF,
  parameter int XY_W    = XY_W_DEF,
  parameter int Z_W     = Z_W_DEF,
  parameter int MAX_XY  = MAX_XY_DEF,
  parameter int MAX_Z   = MAX_Z_DEF,
  parameter int MAX_THR = MAX_THR_DEF,
  localparam int TID_W     = $clog2(MAX_THR + 1),
  localparam int MAX_WARPS = (MAX_THR + LANES - 1) / LANES,
  localparam int WIDX_W    = (MAX_WARPS > 1) ? $clog2(MAX_WARPS) : 1
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [XY_W-1:0]        dimX,
  input  logic [XY_W-1:0]        dimY,
  input  logic [Z_W-1:0]         dimZ,
  input  logic                   outReady,
  output logic                   outValid,
  output logic [WIDX_W-1:0]      warpIdx,
  output logic [LANES-1:0]       activeMask,
  output logic [TID_W-1:0]       baseTid,
  output logic [LANES*TID_W-1:0] laneTid,
  output logic [LANES*XY_W-1:0]  laneX,
  output logic [LANES*XY_W-1:0]  laneY,
  output logic [LANES*Z_W-1:0]   laneZ,
  output logic                   done,
  output logic                   error
);
  dpCtl_t ctl;
  logic   shapeOk, isLast;

  warp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .shapeOk(shapeOk),
    .isLast(isLast), .outReady(outReady), .ctl(ctl),
    .outValid(outValid), .done(done), .error(error)
  );

  warp_dp #(
    .LANES(LANES), .XY_W(XY_W), .Z_W(Z_W),
    .MAX_XY(MAX_XY), .MAX_Z(MAX_Z), .MAX_THR(MAX_THR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .dimX(dimX), .dimY(dimY), .dimZ(dimZ),
    .shapeOk(shapeOk), .isLast(isLast), .warpIdx(warpIdx),
    .activeMask(activeMask), .baseTid(baseTid), .laneTid(laneTid),
    .laneX(laneX), .laneY(laneY), .laneZ(laneZ)
  );
endmodule

// File: rtl/warp_former_chk.sv
module warp_former_chk #(
  parameter int LANES  = 32,
  parameter int TID_W  = 11,
  parameter int WIDX_W = 5
)(
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              outReady,
  input logic              outValid,
  input logic [WIDX_W-1:0] warpIdx,
  input logic [LANES-1:0]  activeMask,
  input logic [TID_W-1:0]  baseTid,
  input logic              done,
  input logic              error
);
  // R6: descriptor holds while stalled
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !start) |=>
      (outValid && $stable(warpIdx) && $stable(activeMask) && $stable(baseTid)));

  // R7: done is a single-cycle pulse following a presented warp
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_after_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(outValid) && !outValid));

  // R5: a refused shape presents nothing
  assert_err_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    error |-> !outValid);

  // R3: active lanes form a contiguous run from lane 0
  assert_mask_contig_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (activeMask[0] && (((activeMask + LANES'(1)) & activeMask) == '0)));

  // R4: an accepted non-final warp is followed by the next index
  assert_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !start) |=>
      (!outValid || (warpIdx == WIDX_W'($past(warpIdx) + 1'b1))));

  // R1: base number tracks the warp index
  assert_base_R1: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (baseTid == TID_W'(warpIdx) * TID_W'(LANES)));
endmodule

bind warp_former warp_former_chk #(
  .LANES(LANES), .TID_W(TID_W), .WIDX_W(WIDX_W)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .outReady(outReady),
  .outValid(outValid), .warpIdx(warpIdx), .activeMask(activeMask),
  .baseTid(baseTid), .done(done), .error(error)
);

// File: tb/warp_former_test.sv
`timescale 1ns/1ps
module warp_former_test;
  localparam int L  = 32;
  localparam int XW = 11;
  localparam int ZW = 7;
  localparam int TW = 11;
  localparam int WW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [XW-1:0] dimX = '0, dimY = '0;
  logic [ZW-1:0] dimZ = '0;
  logic outReady = 1'b0;
  logic outValid, done, error;
  logic [WW-1:0] warpIdx;
  logic [L-1:0]  activeMask;
  logic [TW-1:0] baseTid;
  logic [L*TW-1:0] laneTid;
  logic [L*XW-1:0] laneX, laneY;
  logic [L*ZW-1:0] laneZ;

  always #4 clk = ~clk;

  warp_former uut (
    .clk(clk), .rstN(rstN), .start(start), .dimX(dimX), .dimY(dimY),
    .dimZ(dimZ), .outReady(outReady), .outValid(outValid),
    .warpIdx(warpIdx), .activeMask(activeMask), .baseTid(baseTid),
    .laneTid(laneTid), .laneX(laneX), .laneY(laneY), .laneZ(laneZ),
    .done(done), .error(error)
  );

  int nTests = 0;
  int nFail  = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Dx, Dy, Dz, expected error
  localparam int NV = 13;
  localparam int TBL [NV][4] = '{
    '{1, 1, 1, 0},   '{32, 1, 1, 0}, '{33, 1, 1, 0},  '{4, 3, 2, 0},
    '{0, 4, 4, 1},   '{7, 5, 3, 0},  '{1025, 1, 1, 1}, '{1, 1, 64, 0},
    '{1, 1, 65, 1},  '{64, 32, 1, 1}, '{8, 8, 16, 0},  '{16, 16, 5, 1},
    '{3, 1, 1, 0}
  };

  task automatic checkWarp(input int w, input int dx, input int dy, input int dz);
    int total = dx * dy * dz;
    logic [L-1:0] expMask = '0;
    bit laneOk = 1;
    int badAct = 0, badExp = 0;
    string badWhat = "lanes";
    for (int l = 0; l < L; l++) begin
      int t = w * L + l;
      int ex, ey, ez, et;
      if (t < total) begin
        expMask[l] = 1'b1;
        et = t; ex = t % dx; ey = (t / dx) % dy; ez = t / (dx * dy);
      end else begin
        et = 0; ex = 0; ey = 0; ez = 0;
      end
      if (laneOk && int'(laneTid[l*TW +: TW]) != et) begin
        laneOk = 0; badWhat = "R1 lane tid"; badAct = int'(laneTid[l*TW +: TW]); badExp = et;
      end
      if (laneOk && int'(laneX[l*XW +: XW]) != ex) begin
        laneOk = 0; badWhat = "R2 lane x"; badAct = int'(laneX[l*XW +: XW]); badExp = ex;
      end
      if (laneOk && int'(laneY[l*XW +: XW]) != ey) begin
        laneOk = 0; badWhat = "R2 lane y"; badAct = int'(laneY[l*XW +: XW]); badExp = ey;
      end
      if (laneOk && int'(laneZ[l*ZW +: ZW]) != ez) begin
        laneOk = 0; badWhat = "R2 lane z"; badAct = int'(laneZ[l*ZW +: ZW]); badExp = ez;
      end
    end
    check(outValid == 1'b1, "R4", "valid during warp", outValid, 1);
    check(int'(warpIdx) == w, "R4", "warp index", warpIdx, w);
    check(int'(baseTid) == w * L, "R1", "base thread", baseTid, w * L);
    check(activeMask == expMask, "R3", "active mask", activeMask, expMask);
    check(laneOk, "R2", badWhat, badAct, badExp);
  endtask

  task automatic doStart(input int dx, input int dy, input int dz);
    @(negedge clk);
    start = 1'b1;
    dimX = XW'(dx); dimY = XW'(dy); dimZ = ZW'(dz);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runShape(input int dx, input int dy, input int dz, input int expErr);
    int nw;
    doStart(dx, dy, dz);
    check(int'(error) == expErr, "R5", "error flag", error, expErr);
    if (expErr != 0) begin
      for (int k = 0; k < 2; k++) begin
        check(!outValid && !done, "R5", "no warp for bad shape", outValid, 0);
        @(negedge clk);
      end
      return;
    end
    check(outValid == 1'b1, "R10", "valid after start", outValid, 1);
    nw = (dx * dy * dz + L - 1) / L;
    for (int w = 0; w < nw; w++) begin
      checkWarp(w, dx, dy, dz);
      if (w % 2 == 0) begin
        outReady = 1'b0;
        @(negedge clk);
        checkWarp(w, dx, dy, dz); // R6 stall keeps descriptor
      end
      outReady = 1'b1;
      @(negedge clk);
      outReady = 1'b0;
      if (w == nw - 1) begin
        check(done == 1'b1, "R7", "done after last", done, 1);
        check(outValid == 1'b0, "R7", "valid drops at done", outValid, 0);
        @(negedge clk);
        check(done == 1'b0, "R7", "done one cycle", done, 0);
      end else begin
        check(done == 1'b0, "R7", "no early done", done, 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check(!outValid, "R8", "valid in reset", outValid, 0);
    check(!done, "R8", "done in reset", done, 0);
    check(!error, "R8", "error in reset", error, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!outValid && !done && !error, "R8", "idle after reset",
          {outValid, done, error}, 0);

    for (int v = 0; v < NV; v++)
      runShape(TBL[v][0], TBL[v][1], TBL[v][2], TBL[v][3]);

    // R6 full-rate drain with ready held high: 32 warps in 32 cycles
    begin
      int n = 0;
      doStart(1024, 1, 1);
      outReady = 1'b1;
      while (outValid && n < 100) begin
        n++;
        @(negedge clk);
      end
      outReady = 1'b0;
      check(n == 32, "R6", "back-to-back warp count", n, 32);
      check(done == 1'b1, "R7", "done after full-rate drain", done, 1);
      @(negedge clk);
    end

    // R9 restart in mid-stream
    doStart(100, 1, 1);
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    check(int'(warpIdx) == 1, "R9", "second warp before restart", warpIdx, 1);
    doStart(5, 1, 1);
    check(int'(warpIdx) == 0, "R9", "restart index", warpIdx, 0);
    check(activeMask == 32'h1f, "R9", "restart mask", activeMask, 32'h1f);
    check(int'(baseTid) == 0, "R9", "restart base", baseTid, 0);
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    check(done == 1'b1, "R9", "single warp after restart", done, 1);
    @(negedge clk);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule